// File: doc/BRIEF.md
# Additive Lagged Pseudo-Random Word Generator

This block produces a stream of 36-bit pseudo-random words for memory test sequencers. It holds an accumulator and a bank of eight table words, all loaded with fixed seeds. A pointer walks the bank downwards. On each request the accumulator and the word under the pointer are added modulo 2^36. The sum becomes the new accumulator, replaces the table word, and is presented at the output one cycle later with a one-cycle valid pulse.

A test sequencer takes a snapshot of the complete generator state before it writes a pattern. Before it reads the memory back, it returns to that snapshot, so the read pass regenerates the same words it wrote. Snapshot and return each take one cycle and copy every register in parallel. The shadow copy starts out holding the seed state.

Top module: `addlag_rng`

## Requirements
- R1: After reset `rnd_valid` is 0 and `rnd_word` is 0. The first word produced after reset is twice the seed of entry 7 (octal 543210000076), modulo 2^36.
- R2: Each step forms sum = accumulator + table[pointer] modulo 2^36. The sum is written to both the accumulator and table[pointer], and it is the output word.
- R3: The pointer starts at 7 and drops by one per step, visiting 7,6,5,4,3,2,1,0 and then 7 again.
- R4: `rnd_valid` is high for exactly the cycle after an accepted `step_req`. `rnd_word` changes only on an accepted step and holds its value otherwise.
- R5: `seed_req` reloads all eight entries with their seeds. In octal, entries 0 to 7 are 7654321, 76543210, 765432100, 7654321000, 76543210000, 765432100000, 654321000007 and 543210000076. It also loads the accumulator with the entry-7 seed and sets the pointer to 7.
- R6: `snap_req` copies the accumulator, all table entries and the pointer into shadow storage in one cycle. `back_req` copies them back in one cycle, so the words that follow repeat the words produced after the snapshot.
- R7: When `snap_req` and `back_req` arrive in the same cycle, only the return happens and the shadow keeps its earlier contents.
- R8: A `step_req` in the same cycle as `back_req` or `seed_req` is ignored and produces no valid pulse.
- R9: `seed_req` takes priority over `back_req` and `snap_req`. A snapshot taken in a step cycle captures the state from before that step.
- R10: After reset the shadow holds the seed state, so a return before any snapshot restarts the seeded sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_req | input | 1 | Reload seeds, accumulator and pointer |
| step_req | input | 1 | Produce the next word |
| snap_req | input | 1 | Copy the whole state to the shadow |
| back_req | input | 1 | Copy the shadow back to the live state |
| rnd_word | output | 36 | Last word produced (registered) |
| rnd_valid | output | 1 | One-cycle pulse marking a new word |

## Verification
The hardest situations to reach are the ones where strobes arrive together: a snapshot in the same cycle as a step, a snapshot together with a return, and a step together with a return or a reseed. The stimulus gets there in several ways. It advances the pointer to places where the wrap from 0 to 7 falls inside the replayed window, and then issues each combination of strobes deliberately. It then pulls a run of words and checks them against a behavioural model and against the words recorded right after the snapshot.

// File: rtl/addlag_pkg.sv
package addlag_pkg;

  localparam int unsigned DEF_WORD_W = 36;
  localparam int unsigned DEF_DEPTH  = 8;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_SEED    = 2'd1,
    OP_RETURN  = 2'd2,
    OP_STEP    = 2'd3
  } op_e;

  // Fixed starting contents of the table, indexed modulo eight.
  function automatic logic [35:0] seed_word(input int unsigned k);
    logic [35:0] w;
    case (k % 8)
      0:       w = 36'o000007654321;
      1:       w = 36'o000076543210;
      2:       w = 36'o000765432100;
      3:       w = 36'o007654321000;
      4:       w = 36'o076543210000;
      5:       w = 36'o765432100000;
      6:       w = 36'o654321000007;
      default: w = 36'o543210000076;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/addlag_decode.sv
module addlag_decode
  import addlag_pkg::*;
(
  input  logic seed_req,
  input  logic step_req,
  input  logic snap_req,
  input  logic back_req,
  output op_e  op,
  output logic snap_en
);

  always_comb begin
    if (seed_req)      op = OP_SEED;
    else if (back_req) op = OP_RETURN;
    else if (step_req) op = OP_STEP;
    else               op = OP_IDLE;
  end

  assign snap_en = snap_req && !seed_req && !back_req;

endmodule

// File: rtl/addlag_bank.sv
module addlag_bank
  import addlag_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic              snap_en,
  input  logic [IDX_W-1:0]  ptr,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] seeds  [DEPTH];
  logic [WORD_W-1:0] live   [DEPTH];
  logic [WORD_W-1:0] shadow [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_seed
    assign seeds[g] = WORD_W'(seed_word(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) begin
        live[i]   <= seeds[i];
        shadow[i] <= seeds[i];
      end else begin
        case (op)
          OP_SEED:   live[i] <= seeds[i];
          OP_RETURN: live[i] <= shadow[i];
          OP_STEP:   if (ptr == IDX_W'(i)) live[i] <= wr_word;
          default:   ;
        endcase
        if (snap_en) shadow[i] <= live[i];
      end
    end
  end

  assign rd_word = live[ptr];

endmodule

// File: rtl/addlag_core.sv
module addlag_core
  import addlag_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic              snap_en,
  input  logic [WORD_W-1:0] rd_word,
  output logic [IDX_W-1:0]  ptr,
  output logic [IDX_W-1:0]  sh_ptr,
  output logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] sum,
  output logic [WORD_W-1:0] word_q,
  output logic              valid_q
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DEPTH - 1);

  logic [WORD_W-1:0] top_seed;
  logic [WORD_W-1:0] sh_acc;
  logic [IDX_W-1:0]  ptr_dn;

  assign top_seed = WORD_W'(seed_word(DEPTH - 1));
  assign sum      = acc + rd_word;
  assign ptr_dn   = (ptr == '0) ? TOP_IDX : ptr - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= top_seed;
      ptr     <= TOP_IDX;
      sh_acc  <= top_seed;
      sh_ptr  <= TOP_IDX;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= (op == OP_STEP);
      case (op)
        OP_SEED: begin
          acc <= top_seed;
          ptr <= TOP_IDX;
        end
        OP_RETURN: begin
          acc <= sh_acc;
          ptr <= sh_ptr;
        end
        OP_STEP: begin
          acc    <= sum;
          ptr    <= ptr_dn;
          word_q <= sum;
        end
        default: ;
      endcase
      if (snap_en) begin
        sh_acc <= acc;
        sh_ptr <= ptr;
      end
    end
  end

endmodule

// File: rtl/addlag_rng.sv
module addlag_rng
  import addlag_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seed_req,
  input  logic              step_req,
  input  logic              snap_req,
  input  logic              back_req,
  output logic [WORD_W-1:0] rnd_word,
  output logic              rnd_valid
);

  op_e               op;
  logic              snap_en;
  logic [IDX_W-1:0]  ptr_q;
  logic [IDX_W-1:0]  sh_ptr_q;
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] sum_w;
  logic [WORD_W-1:0] entry_w;

  addlag_decode i_decode (
    .seed_req (seed_req),
    .step_req (step_req),
    .snap_req (snap_req),
    .back_req (back_req),
    .op       (op),
    .snap_en  (snap_en)
  );

  addlag_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_bank (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .snap_en (snap_en),
    .ptr     (ptr_q),
    .wr_word (sum_w),
    .rd_word (entry_w)
  );

  addlag_core #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_core (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .snap_en (snap_en),
    .rd_word (entry_w),
    .ptr     (ptr_q),
    .sh_ptr  (sh_ptr_q),
    .acc     (acc_q),
    .sum     (sum_w),
    .word_q  (rnd_word),
    .valid_q (rnd_valid)
  );

endmodule

// File: rtl/addlag_rng_chk.sv
module addlag_rng_chk #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              seed_req,
  input logic              step_req,
  input logic              snap_req,
  input logic              back_req,
  input logic [WORD_W-1:0] rnd_word,
  input logic              rnd_valid,
  input logic [WORD_W-1:0] acc,
  input logic [IDX_W-1:0]  ptr,
  input logic [IDX_W-1:0]  sh_ptr
);

  logic accepted;
  assign accepted = step_req && !seed_req && !back_req;

  assert_step_valid_R4: assert property (@(posedge clk) disable iff (rst)
    accepted |=> rnd_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !accepted |=> !rnd_valid);

  assert_hold_word_R4: assert property (@(posedge clk) disable iff (rst)
    !accepted |=> $stable(rnd_word));

  assert_word_is_acc_R2: assert property (@(posedge clk) disable iff (rst)
    rnd_valid |-> rnd_word == acc);

  assert_ptr_walk_R3: assert property (@(posedge clk) disable iff (rst)
    accepted |=> ptr == (($past(ptr) == '0) ? IDX_W'(DEPTH - 1) : $past(ptr) - 1'b1));

  assert_seed_ptr_R5: assert property (@(posedge clk) disable iff (rst)
    seed_req |=> ptr == IDX_W'(DEPTH - 1));

  assert_return_ptr_R6: assert property (@(posedge clk) disable iff (rst)
    (back_req && !seed_req) |=> ptr == $past(sh_ptr));

  assert_return_beats_snap_R7: assert property (@(posedge clk) disable iff (rst)
    (back_req && snap_req) |=> $stable(sh_ptr));

endmodule

bind addlag_rng addlag_rng_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .seed_req  (seed_req),
  .step_req  (step_req),
  .snap_req  (snap_req),
  .back_req  (back_req),
  .rnd_word  (rnd_word),
  .rnd_valid (rnd_valid),
  .acc       (acc_q),
  .ptr       (ptr_q),
  .sh_ptr    (sh_ptr_q)
);

// File: tb/test_addlag_rng.sv
`timescale 1ns/1ps
module test_addlag_rng;

  localparam longint unsigned MASK = 64'hF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seed_req = 1'b0, step_req = 1'b0, snap_req = 1'b0, back_req = 1'b0;
  logic [35:0] rnd_word;
  logic        rnd_valid;

  always #2.5 clk = ~clk;

  addlag_rng i_addlag_rng (
    .clk(clk), .rst(rst), .seed_req(seed_req), .step_req(step_req),
    .snap_req(snap_req), .back_req(back_req),
    .rnd_word(rnd_word), .rnd_valid(rnd_valid)
  );

  // behavioural reference
  longint unsigned seeds [8];
  longint unsigned m_tbl [8];
  longint unsigned s_tbl [8];
  longint unsigned m_acc, s_acc, m_word;
  int              m_ptr, s_ptr;
  bit              m_valid;

  int tests = 0, fails = 0;
  bit done = 0;
  longint unsigned last_word;
  longint unsigned recorded[$];

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  task automatic model_seed();
    for (int i = 0; i < 8; i++) m_tbl[i] = seeds[i];
    m_acc = seeds[7];
    m_ptr = 7;
  endtask

  task automatic model_reset();
    model_seed();
    for (int i = 0; i < 8; i++) s_tbl[i] = seeds[i];
    s_acc = seeds[7]; s_ptr = 7;
    m_word = 0; m_valid = 0;
  endtask

  task automatic model_cycle(input bit sd, input bit st, input bit sn, input bit bk);
    longint unsigned n_tbl [8];
    longint unsigned n_acc;
    int n_ptr;
    n_tbl = m_tbl; n_acc = m_acc; n_ptr = m_ptr;
    m_valid = 0;
    if (sd) begin
      model_seed(); n_tbl = m_tbl; n_acc = m_acc; n_ptr = m_ptr;
    end else if (bk) begin
      n_tbl = s_tbl; n_acc = s_acc; n_ptr = s_ptr;
    end else if (st) begin
      n_acc = (m_acc + m_tbl[m_ptr]) & MASK;
      n_tbl[m_ptr] = n_acc;
      n_ptr = (m_ptr == 0) ? 7 : m_ptr - 1;
      m_word = n_acc; m_valid = 1;
    end
    if (sn && !sd && !bk) begin
      s_tbl = m_tbl; s_acc = m_acc; s_ptr = m_ptr;
    end
    m_tbl = n_tbl; m_acc = n_acc; m_ptr = n_ptr;
  endtask

  // one clock: compare at negedge, then drive the next inputs
  task automatic cyc(input bit sd, input bit st, input bit sn, input bit bk);
    @(negedge clk);
    check("R4 valid", rnd_valid, m_valid);
    check("R2 word", rnd_word, m_word);
    last_word = rnd_word;
    seed_req = sd; step_req = st; snap_req = sn; back_req = bk;
    model_cycle(sd, st, sn, bk);
  endtask

  task automatic pull(output longint unsigned w);
    cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 0);
    w = last_word;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    longint unsigned w;
    seeds[0] = 36'o000007654321; seeds[1] = 36'o000076543210;
    seeds[2] = 36'o000765432100; seeds[3] = 36'o007654321000;
    seeds[4] = 36'o076543210000; seeds[5] = 36'o765432100000;
    seeds[6] = 36'o654321000007; seeds[7] = 36'o543210000076;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 reset valid", rnd_valid, 0);
    check("R1 reset word", rnd_word, 0);
    pull(w);
    check("R1 first word", w, (2 * seeds[7]) & MASK);
    // R3 wrap across more than one lap, with gaps
    for (int i = 0; i < 20; i++) begin
      cyc(0, 1, 0, 0);
      if (i % 3 == 0) cyc(0, 0, 0, 0);
    end
    // R10 return before any snapshot restarts the seeded run
    cyc(0, 0, 0, 1);
    pull(w);
    check("R10 shadow seeded", w, (2 * seeds[7]) & MASK);
    // R6 snapshot, record, return, replay (window crosses the wrap)
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 0);
    for (int i = 0; i < 12; i++) begin pull(w); recorded.push_back(w); end
    cyc(0, 0, 0, 1);
    for (int i = 0; i < 12; i++) begin pull(w); check("R6 replay", w, recorded[i]); end
    // R7 snap and return together: shadow kept
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 1);
    for (int i = 0; i < 12; i++) begin pull(w); check("R7 replay", w, recorded[i]); end
    cyc(0, 0, 0, 1);
    for (int i = 0; i < 4; i++) begin pull(w); check("R7 shadow kept", w, recorded[i]); end
    // R8 step with return / seed ignored
    cyc(0, 1, 0, 1);
    cyc(0, 0, 0, 0);
    check("R8 no pulse on return", rnd_valid, 0);
    cyc(1, 1, 0, 0);
    cyc(0, 0, 0, 0);
    check("R8 no pulse on seed", rnd_valid, 0);
    // R5 reseed restarts the sequence
    pull(w);
    check("R5 reseed first word", w, (2 * seeds[7]) & MASK);
    // R9 seed beats return and snapshot; snapshot with step keeps pre-step state
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0);
    cyc(1, 0, 1, 1);
    pull(w);
    check("R9 seed wins", w, (2 * seeds[7]) & MASK);
    for (int i = 0; i < 2; i++) cyc(0, 1, 0, 0);
    cyc(0, 1, 1, 0);
    cyc(0, 0, 0, 0);
    w = last_word;
    for (int i = 0; i < 9; i++) cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 1);
    pull(last_word);
    check("R9 snapshot before step", last_word, w);
    // back-to-back stream
    for (int i = 0; i < 30; i++) cyc(0, 1, 0, 0);
    repeat (3) cyc(0, 0, 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule